// File: doc/BRIEF.md
# Quad Prescaled Down-Counter Timer

This block holds four independent decrementing counters behind a simple word-addressed register bus. Software arms a channel by choosing its width (16 or 32 bits), its clock divider (1, 16 or 256), and its behaviour at zero. At zero a channel can stop (one-shot), wrap to the all-ones value (free-running), or restart from a stored reload value (periodic). Each channel also has a "next" reload register. It can be rewritten while the channel runs without disturbing the live count, so a new period is picked up cleanly at the following wrap.

A shared interrupt section records a raw event bit per channel whenever a counter reaches zero. It combines those bits with an enable mask into a pending view and one interrupt line. Raw bits are cleared by writing ones to an acknowledge address. The bus is a plain single-cycle register port. Writes complete on the clock edge where `bus_we` is high. A read issued with `bus_re` returns its data one cycle later, flagged by `bus_rvalid`. The port has no ready signal and cannot be stalled, so no back-pressure exists: every read is answered exactly one cycle after it is issued.

Top module: `tmr4_unit`

## Requirements
- R1: After reset every readable register returns 0 and `irq_o` is low.
- R2: The address map is as follows, with word addresses in bytes. Shared registers: 0x00 interrupt mask (read/write), 0x04 raw events, 0x08 pending (raw AND mask), 0x0C acknowledge (reads 0). Channel n sits at 0x10+0x10·n: +0x0 load, +0x4 live count, +0x8 control, +0xC next reload. Both load and next-reload read back the stored reload value. A read with `bus_re` high returns data with `bus_rvalid` high on the following cycle. A read at an address whose two low bits are not zero returns 0.
- R3: The control fields are: bit 7 enable, bit 6 periodic, bits 3:2 divider select, bit 1 32-bit width, bit 0 one-shot. The register reads back those bits and returns 0 elsewhere.
- R4: Writing a channel's load register sets its count to the written value on the same edge (masked to the active width). It also sets the reload value and restarts the divider.
- R5: Writing the next-reload register changes only the reload value. The live count is untouched.
- R6: The divider select works as follows: 00 counts every cycle, 01 every 16 cycles, 10 and 11 every 256 cycles. The first tick after a load or after enabling comes one full divider period later.
- R7: In 16-bit mode only the low 16 bits count and wrap. The upper 16 bits of the live count read as 0.
- R8: When the periodic bit is clear and one-shot is clear, a tick at zero wraps the count to the all-ones value of the active width.
- R9: When the periodic bit is set and one-shot is clear, a tick at zero reloads the most recently written load or next-reload value.
- R10: When one-shot is set, the count stays at zero once it gets there.
- R11: A tick that takes a count from 1 to 0 sets that channel's raw bit (bit n for channel n). Pending equals raw AND mask, and `irq_o` is the OR of the pending bits.
- R12: Writing the acknowledge address clears exactly those raw bits written as 1. A new event in the same cycle wins.
- R13: A disabled channel holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The properties assume that reset is asserted before the first edge and that the bus carries at most one access per cycle. That single access means a channel's control and load registers are never written together, which the load-visibility check relies on. The acknowledge property takes same-cycle events as winning over a clear, so it only constrains bits without a concurrent event. The stimulus issues strictly one write or one read per cycle at aligned addresses, except for one deliberate misaligned read. It times every running-counter observation either by stopping the channel on a known edge or by sampling raw events in windows well clear of the expected tick.

// File: rtl/tmr4_pkg.sv
package tmr4_pkg;

  typedef struct packed {
    logic       en;
    logic       per;
    logic [1:0] ps;
    logic       wide;
    logic       once;
  } tmr_ctrl_t;

  typedef enum logic [1:0] {
    SR_MASK = 2'd0,
    SR_RAW  = 2'd1,
    SR_PEND = 2'd2,
    SR_ACK  = 2'd3
  } shr_e;

  typedef enum logic [1:0] {
    CR_LOAD  = 2'd0,
    CR_COUNT = 2'd1,
    CR_CTRL  = 2'd2,
    CR_NEXT  = 2'd3
  } chr_e;

  function automatic logic [7:0] ctrl_pack(tmr_ctrl_t c);
    return {c.en, c.per, 2'b00, c.ps, c.wide, c.once};
  endfunction

endpackage

// File: rtl/tmr4_prescale.sv
module tmr4_prescale #(
  parameter int unsigned DIV_MID = 16,
  parameter int unsigned DIV_HI  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int unsigned PW = $clog2(DIV_HI);
  localparam logic [PW-1:0] LAST_MID = PW'(DIV_MID - 1);
  localparam logic [PW-1:0] LAST_HI  = PW'(DIV_HI - 1);

  logic [PW-1:0] pre;
  logic [PW-1:0] last;

  always_comb begin
    case (sel)
      2'b00:   last = '0;
      2'b01:   last = LAST_MID;
      default: last = LAST_HI;
    endcase
  end

  assign tick = run && !restart && (pre >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre <= '0;
    else if (!run || restart)  pre <= '0;
    else if (pre >= last)      pre <= '0;
    else                       pre <= pre + PW'(1);
  end
endmodule

// File: rtl/tmr4_channel.sv
module tmr4_channel
  import tmr4_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned DIV_MID  = 16,
  parameter int unsigned DIV_HI   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic              nx_we,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wdata,
  output tmr_ctrl_t         ctrl,
  output logic [DATA_W-1:0] cnt_rd,
  output logic [DATA_W-1:0] rl_rd,
  output logic              hit
);
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] rl;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] cur;
  logic              tick;
  logic              at_zero;

  assign wmask   = ctrl.wide ? '1 : NARROW_MASK;
  assign cur     = cnt & wmask;
  assign at_zero = (cur == '0);

  tmr4_prescale #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.en),
    .restart (ld_we),
    .sel     (ctrl.ps),
    .tick    (tick)
  );

  assign hit    = tick && (cur == DATA_W'(1));
  assign cnt_rd = cur;
  assign rl_rd  = rl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctl_we) begin
      ctrl <= '{en: wdata[7], per: wdata[6], ps: wdata[3:2],
                wide: wdata[1], once: wdata[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rl  <= '0;
    end else if (ld_we) begin
      cnt <= wdata & wmask;
      rl  <= wdata;
    end else begin
      if (nx_we) rl <= wdata;
      if (tick) begin
        if (!at_zero)       cnt <= cur - DATA_W'(1);
        else if (ctrl.once) cnt <= cur;
        else if (ctrl.per)  cnt <= rl & wmask;
        else                cnt <= wmask;
      end
    end
  end
endmodule

// File: rtl/tmr4_irq.sv
module tmr4_irq #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              ack_we,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] hits,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] raw,
  output logic [NUM_CH-1:0] pend,
  output logic              irq
);
  logic [NUM_CH-1:0] ack_bits;

  assign ack_bits = ack_we ? wbits : '0;
  assign pend     = raw & mask;
  assign irq      = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      raw  <= '0;
    end else begin
      if (mask_we) mask <= wbits;
      raw <= (raw & ~ack_bits) | hits;
    end
  end
endmodule

// File: rtl/tmr4_unit.sv
module tmr4_unit
  import tmr4_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned DIV_MID  = 16,
  parameter int unsigned DIV_HI   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_o
);
  localparam int unsigned BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0]  blk;
  logic [1:0]        reg_sel;
  logic              aligned;
  logic              shr_sel;

  tmr_ctrl_t         ch_ctrl [NUM_CH];
  logic [DATA_W-1:0] ch_cnt  [NUM_CH];
  logic [DATA_W-1:0] ch_rl   [NUM_CH];
  logic [NUM_CH-1:0] ch_hit;
  logic [NUM_CH-1:0] ch_ld_we;
  logic [NUM_CH-1:0] ch_wide;

  logic [NUM_CH-1:0] irq_mask;
  logic [NUM_CH-1:0] irq_raw;
  logic [NUM_CH-1:0] irq_pend;
  logic              irq_comb;

  logic [DATA_W-1:0] rd_mux;

  assign blk     = bus_addr[ADDR_W-1:4];
  assign reg_sel = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign shr_sel = aligned && (blk == '0);

  generate
    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic sel;
      assign sel = aligned && (blk == BLK_W'(gi + 1));
      assign ch_ld_we[gi] = bus_we && sel && (reg_sel == CR_LOAD);
      assign ch_wide[gi]  = ch_ctrl[gi].wide;

      tmr4_channel #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .DIV_MID  (DIV_MID),
        .DIV_HI   (DIV_HI)
      ) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_we  (ch_ld_we[gi]),
        .nx_we  (bus_we && sel && (reg_sel == CR_NEXT)),
        .ctl_we (bus_we && sel && (reg_sel == CR_CTRL)),
        .wdata  (bus_wdata),
        .ctrl   (ch_ctrl[gi]),
        .cnt_rd (ch_cnt[gi]),
        .rl_rd  (ch_rl[gi]),
        .hit    (ch_hit[gi])
      );
    end
  endgenerate

  tmr4_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (bus_we && shr_sel && (reg_sel == SR_MASK)),
    .ack_we  (bus_we && shr_sel && (reg_sel == SR_ACK)),
    .wbits   (bus_wdata[NUM_CH-1:0]),
    .hits    (ch_hit),
    .mask    (irq_mask),
    .raw     (irq_raw),
    .pend    (irq_pend),
    .irq     (irq_comb)
  );

  assign irq_o = irq_comb;

  always_comb begin
    rd_mux = '0;
    if (shr_sel) begin
      case (reg_sel)
        SR_MASK: rd_mux = {{(DATA_W-NUM_CH){1'b0}}, irq_mask};
        SR_RAW:  rd_mux = {{(DATA_W-NUM_CH){1'b0}}, irq_raw};
        SR_PEND: rd_mux = {{(DATA_W-NUM_CH){1'b0}}, irq_pend};
        default: rd_mux = '0;
      endcase
    end else if (aligned) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (blk == BLK_W'(i + 1)) begin
          case (reg_sel)
            CR_COUNT: rd_mux = ch_cnt[i];
            CR_CTRL:  rd_mux = {{(DATA_W-8){1'b0}}, ctrl_pack(ch_ctrl[i])};
            default:  rd_mux = ch_rl[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/tmr4_unit_chk.sv
module tmr4_unit_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              bus_rvalid,
  input logic              irq_o,
  input logic [NUM_CH-1:0] raw,
  input logic [NUM_CH-1:0] mask,
  input logic [NUM_CH-1:0] hits,
  input logic              ld_we0,
  input logic              wide0,
  input logic [DATA_W-1:0] cnt0
);
  logic ack_acc;
  assign ack_acc = bus_we && (bus_addr == ADDR_W'('hC));

  p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);

  p_no_spurious_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !bus_rvalid);

  p_load_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we0 && wide0) |=> (cnt0 == $past(bus_wdata)));

  p_hit_latches_raw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hits != '0) |=> ((raw & $past(hits)) == $past(hits)));

  p_raw_needs_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~$past(raw) & ~$past(hits)) == '0));

  p_irq_needs_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);

  p_irq_needs_raw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |-> !irq_o);

  p_ack_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_acc |=> ((raw & $past(bus_wdata[NUM_CH-1:0]) & ~$past(hits)) == '0));
endmodule

bind tmr4_unit tmr4_unit_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rvalid (bus_rvalid),
  .irq_o      (irq_o),
  .raw        (irq_raw),
  .mask       (irq_mask),
  .hits       (ch_hit),
  .ld_we0     (ch_ld_we[0]),
  .wide0      (ch_wide[0]),
  .cnt0       (ch_cnt[0])
);

// File: tb/tmr4_unit_tb.sv
`timescale 1ns/1ps
module tmr4_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  tmr4_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_o(irq_o)
  );

  localparam logic [11:0] A_MASK = 12'h000, A_RAW = 12'h004,
                          A_PEND = 12'h008, A_ACK = 12'h00C;

  function automatic logic [11:0] ca(int ch, int r);
    return 12'(16 + 16 * ch + 4 * r);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_re = 1'b0; bus_addr = a; bus_wdata = d;
    @(posedge clk);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
    end
  endtask

  task automatic check_irq(logic e, string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    checks++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s: irq_o got %0b expected %0b", tag, irq_o, e);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected read data: got 0x%08h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: got 0x%08h expected 0x%08h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_irq(1'b0, "R1 irq after reset");
    rd(A_MASK, 32'h0, "R1 mask reset");
    rd(A_RAW,  32'h0, "R1 raw reset");
    rd(A_PEND, 32'h0, "R1 pend reset");
    rd(A_ACK,  32'h0, "R1 ack reset");
    rd(ca(0, 0), 32'h0, "R1 ch0 load reset");
    rd(ca(0, 1), 32'h0, "R1 ch0 count reset");
    rd(ca(0, 2), 32'h0, "R1 ch0 ctrl reset");
    rd(ca(3, 3), 32'h0, "R1 ch3 next reset");

    // R4 load with channel disabled, R3 readback
    wr(ca(1, 2), 32'hFFFF_FF42);
    rd(ca(1, 2), 32'h42, "R3 ctrl readback drops unused bits");
    wr(ca(1, 0), 32'h1234_5678);
    rd(ca(1, 1), 32'h1234_5678, "R4 load sets count");
    rd(ca(1, 0), 32'h1234_5678, "R2 load reads reload");
    rd(ca(1, 0) + 12'h1, 32'h0, "R2 misaligned read");

    // R7 16-bit masking
    wr(ca(2, 2), 32'h00);
    wr(ca(2, 0), 32'hABCD_0003);
    rd(ca(2, 1), 32'h0000_0003, "R7 upper bits read zero");

    // R5 next reload does not disturb count; R9 periodic from next value
    wr(ca(1, 0), 32'd2);
    wr(ca(1, 3), 32'd7);
    rd(ca(1, 1), 32'd2, "R5 next write keeps count");
    rd(ca(1, 3), 32'd7, "R5 next readback");
    wr(ca(1, 2), 32'hC2);
    idle(3);
    wr(ca(1, 2), 32'h42);
    rd(ca(1, 1), 32'd6, "R9 periodic reload from next value");
    idle(20);
    rd(ca(1, 1), 32'd6, "R13 disabled channel holds");

    // R9 periodic reload from load value
    wr(ca(1, 0), 32'd2);
    wr(ca(1, 2), 32'hC2);
    idle(3);
    wr(ca(1, 2), 32'h42);
    rd(ca(1, 1), 32'd1, "R9 periodic reload from load value");

    // R8 free-running 32-bit wrap
    wr(ca(1, 2), 32'h02);
    wr(ca(1, 0), 32'd1);
    wr(ca(1, 2), 32'h82);
    idle(1);
    wr(ca(1, 2), 32'h02);
    rd(ca(1, 1), 32'hFFFF_FFFF, "R8 32-bit wrap to all ones");

    // R7 / R8 free-running 16-bit wrap
    wr(ca(2, 0), 32'd0);
    wr(ca(2, 2), 32'h80);
    wr(ca(2, 2), 32'h00);
    rd(ca(2, 1), 32'h0000_FFFF, "R7 16-bit wrap stays in low half");

    // R10 / R11 / R12 one-shot and interrupt views
    wr(A_ACK, 32'hF);
    wr(ca(0, 2), 32'h83);
    wr(ca(0, 0), 32'd10);
    idle(30);
    rd(ca(0, 1), 32'd0, "R10 one-shot stays at zero");
    rd(A_RAW,  32'h1, "R11 raw set on reaching zero");
    rd(A_PEND, 32'h0, "R11 pend masked off");
    check_irq(1'b0, "R11 irq low while masked");
    wr(A_MASK, 32'h1);
    rd(A_PEND, 32'h1, "R11 pend with mask");
    check_irq(1'b1, "R11 irq high when masked in");
    wr(A_ACK, 32'h2);
    rd(A_RAW, 32'h1, "R12 ack leaves unwritten bits");
    wr(A_ACK, 32'h1);
    rd(A_RAW, 32'h0, "R12 ack clears written bit");
    check_irq(1'b0, "R12 irq low after ack");
    wr(A_MASK, 32'h0);

    // R6 divide by 16
    wr(ca(3, 2), 32'h07);
    wr(ca(3, 0), 32'd3);
    wr(ca(3, 2), 32'h87);
    idle(38);
    rd(A_RAW, 32'h0, "R6 div16 not yet at zero");
    idle(15);
    rd(A_RAW, 32'h8, "R6 div16 reached zero after 48");
    rd(ca(3, 1), 32'd0, "R6 div16 count zero");

    // R6 divide by 256 with codes 10 and 11
    wr(A_ACK, 32'hF);
    wr(ca(2, 2), 32'h0B);
    wr(ca(2, 0), 32'd1);
    wr(ca(3, 2), 32'h0F);
    wr(ca(3, 0), 32'd1);
    wr(ca(2, 2), 32'h8B);
    wr(ca(3, 2), 32'h8F);
    rd(ca(3, 2), 32'h8F, "R3 ctrl readback all fields");
    idle(200);
    rd(A_RAW, 32'h0, "R6 div256 not yet ticked");
    idle(100);
    rd(A_RAW, 32'hC, "R6 div256 codes 10 and 11 ticked");

    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 reads left unanswered: got %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule